// File: doc/BRIEF.md
# Machine Timer with Software Interrupts

This block is a bus-accessible machine timer for a single hart. It holds a 64-bit counter and a 64-bit compare value. It raises a level timer interrupt while the counter has reached the compare value. Alongside the timer it provides two software-interrupt bits, one for machine mode and one for supervisor mode, a bit that grants the supervisor mode access, and a keyed register that issues a one-cycle core reset request.

A host reaches all state through a simple 32-bit bus. The bus transfers one word per cycle: a write takes effect at the clock edge, and read data is returned combinationally in the same cycle. Each 64-bit value is split into a low word and a high word. The counter advances by all 64 bits in a single cycle, so software can read it safely by reading the high word, then the low word, then the high word again. Software writes the high word and then the low word. A second address window places the software bits, the compare value and the counter at interrupt-controller-style offsets that depend on the hart index parameter.

Top module: `mtimer_unit`

## Requirements
- R1: The counter reads as a low word at 0x000 and a high word at 0x004. With control bits 0, 2 and 3 clear, it advances by one every clock cycle. A carry from the low word into the high word happens in the same cycle.
- R2: The compare value reads as a low word at 0x008 and a high word at 0x00C. irq_timer is high whenever the counter is unsigned greater than or equal to the compare value. It falls in the cycle after the compare value is rewritten above the counter.
- R3: The control register sits at 0xFF8 and reads back in bits 4:0; bits 31:5 read 0. Bit 0 set freezes the counter. With bit 3 set, the counter is frozen while debug_halt is high. With bit 2 set, the counter advances only on cycles where aux_tick is high. Bit 4 is storage only.
- R4: With control bit 1 set, a counting cycle that finds counter ≥ compare sets the counter to 0 instead of incrementing it. It also sets a pending flag that keeps irq_timer high until either compare word is written.
- R5: A write to one counter word replaces only that word and keeps the other. The counter does not advance in that cycle.
- R6: Bit 0 of the register at 0xFFC drives irq_msw, and bit 0 of the register at 0xFF4 drives irq_ssw, from the cycle after the write. Their upper bits read 0.
- R7: Bit 0 at 0xFEC grants the supervisor mode access. While it is clear, an access with req_priv_s high reads 0 and its write is dropped. A supervisor write to 0xFEC itself is always dropped. Machine accesses are never blocked.
- R8: Writing exactly 0x80000A5F to 0xFF0 drives core_rst_req high for exactly the next cycle. Any other value does nothing, and the register reads 0.
- R9: An alias window mirrors the same state: the machine software bit at 0x1000+4×HART_ID, the compare words at 0x5000+8×HART_ID and +4, the counter words at 0xCFF8 and 0xCFFC, and the supervisor software bit at 0xD000+4×HART_ID.
- R10: After reset the counter is 0, the compare value is all ones, and all control, software, access and pending bits are 0. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_tick | input | 1 | Count-enable pulse used when the alternate source is selected |
| debug_halt | input | 1 | Hart is in debug mode |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv_s | input | 1 | Access comes from supervisor mode |
| req_addr | input | 16 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the access cycle |
| irq_timer | output | 1 | Timer interrupt (level) |
| irq_msw | output | 1 | Machine software interrupt |
| irq_ssw | output | 1 | Supervisor software interrupt |
| core_rst_req | output | 1 | One-cycle core reset request |

## Verification
The hardest condition to reach from the ports is the pending flag of the auto-clear mode. The bench first parks the counter just below a small compare value with two word writes. It then enables clear-on-compare and lets the counter wrap several times. Over those cycles irq_timer must stay high even though the counter sits below the compare value. The flag is cleared by rewriting the compare word. The carry case is reached the same way: the low word is loaded a few counts below its maximum, and the high word is read after the wrap.

// File: rtl/mtimer_unit.sv
module mtimer_unit #(
  parameter int          HART_ID = 0,
  parameter logic [31:0] RST_KEY = 32'h8000_0A5F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        aux_tick,
  input  logic        debug_halt,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_priv_s,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        irq_timer,
  output logic        irq_msw,
  output logic        irq_ssw,
  output logic        core_rst_req
);
  localparam int TW = 64;
  localparam logic [15:0] A_CNT_LO = 16'h0000;
  localparam logic [15:0] A_CNT_HI = 16'h0004;
  localparam logic [15:0] A_CMP_LO = 16'h0008;
  localparam logic [15:0] A_CMP_HI = 16'h000C;
  localparam logic [15:0] A_SACC   = 16'h0FEC;
  localparam logic [15:0] A_SRST   = 16'h0FF0;
  localparam logic [15:0] A_SSW    = 16'h0FF4;
  localparam logic [15:0] A_CTL    = 16'h0FF8;
  localparam logic [15:0] A_MSW    = 16'h0FFC;
  localparam logic [15:0] W_MSW    = 16'(32'h1000 + 4 * HART_ID);
  localparam logic [15:0] W_CMP_LO = 16'(32'h5000 + 8 * HART_ID);
  localparam logic [15:0] W_CMP_HI = 16'(32'h5004 + 8 * HART_ID);
  localparam logic [15:0] W_CNT_LO = 16'hCFF8;
  localparam logic [15:0] W_CNT_HI = 16'hCFFC;
  localparam logic [15:0] W_SSW    = 16'(32'hD000 + 4 * HART_ID);

  logic [TW-1:0] cnt_q, cmp_q;
  logic [4:0]    ctl_q;
  logic          msw_q, ssw_q, sacc_q, pend_q, rst_q;

  logic granted, wr, rd;
  logic s_cnt_lo, s_cnt_hi, s_cmp_lo, s_cmp_hi, s_msw, s_ssw;
  logic cnt_wr, cmp_wr, tick, ge;

  assign granted  = req_valid & (~req_priv_s | sacc_q);
  assign wr       = granted & req_write;
  assign rd       = granted & ~req_write;

  assign s_cnt_lo = (req_addr == A_CNT_LO) | (req_addr == W_CNT_LO);
  assign s_cnt_hi = (req_addr == A_CNT_HI) | (req_addr == W_CNT_HI);
  assign s_cmp_lo = (req_addr == A_CMP_LO) | (req_addr == W_CMP_LO);
  assign s_cmp_hi = (req_addr == A_CMP_HI) | (req_addr == W_CMP_HI);
  assign s_msw    = (req_addr == A_MSW)    | (req_addr == W_MSW);
  assign s_ssw    = (req_addr == A_SSW)    | (req_addr == W_SSW);

  assign cnt_wr = wr & (s_cnt_lo | s_cnt_hi);
  assign cmp_wr = wr & (s_cmp_lo | s_cmp_hi);
  assign tick   = ~ctl_q[0] & ~(ctl_q[3] & debug_halt) & (~ctl_q[2] | aux_tick);
  assign ge     = cnt_q >= cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (s_cnt_lo) cnt_q[31:0]  <= req_wdata;
      else          cnt_q[63:32] <= req_wdata;
    end else if (tick) begin
      cnt_q <= (ctl_q[1] && ge) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      if (cmp_wr) begin
        if (s_cmp_lo) cmp_q[31:0]  <= req_wdata;
        else          cmp_q[63:32] <= req_wdata;
        pend_q <= 1'b0;
      end else if (tick && !cnt_wr && ctl_q[1] && ge) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      msw_q  <= 1'b0;
      ssw_q  <= 1'b0;
      sacc_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= wr && req_addr == A_SRST && req_wdata == RST_KEY;
      if (wr && req_addr == A_CTL)                 ctl_q  <= req_wdata[4:0];
      if (wr && s_msw)                             msw_q  <= req_wdata[0];
      if (wr && s_ssw)                             ssw_q  <= req_wdata[0];
      if (wr && !req_priv_s && req_addr == A_SACC) sacc_q <= req_wdata[0];
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (rd) begin
      if (s_cnt_lo)                rsp_rdata = cnt_q[31:0];
      else if (s_cnt_hi)           rsp_rdata = cnt_q[63:32];
      else if (s_cmp_lo)           rsp_rdata = cmp_q[31:0];
      else if (s_cmp_hi)           rsp_rdata = cmp_q[63:32];
      else if (s_msw)              rsp_rdata = {31'd0, msw_q};
      else if (s_ssw)              rsp_rdata = {31'd0, ssw_q};
      else if (req_addr == A_CTL)  rsp_rdata = {27'd0, ctl_q};
      else if (req_addr == A_SACC) rsp_rdata = {31'd0, sacc_q};
    end
  end

  assign irq_timer    = ge | pend_q;
  assign irq_msw      = msw_q;
  assign irq_ssw      = ssw_q;
  assign core_rst_req = rst_q;
endmodule

// File: rtl/mtimer_unit_chk.sv
module mtimer_unit_chk #(
  parameter logic [31:0] RST_KEY = 32'h8000_0A5F
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_priv_s,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic [31:0] rsp_rdata,
  input logic        irq_timer,
  input logic        irq_msw,
  input logic        core_rst_req,
  input logic [63:0] cnt_q,
  input logic [63:0] cmp_q,
  input logic [4:0]  ctl_q,
  input logic        sacc_q,
  input logic        tick,
  input logic        cnt_wr
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !(ctl_q[1] && cnt_q >= cmp_q)) |=> cnt_q == $past(cnt_q) + 64'd1);
  // R2
  level_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= cmp_q) |-> irq_timer);
  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !cnt_wr) |=> $stable(cnt_q));
  // R6
  msw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_priv_s && req_addr == 16'h0FFC) |=> irq_msw == $past(req_wdata[0]));
  // R7
  s_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_priv_s && !sacc_q) |-> rsp_rdata == 32'd0);
  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req |=> !core_rst_req);
  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_req |-> $past(req_valid && req_write && req_addr == 16'h0FF0 && req_wdata == RST_KEY));
endmodule

bind mtimer_unit mtimer_unit_chk #(.RST_KEY(RST_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_priv_s(req_priv_s), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_rdata(rsp_rdata), .irq_timer(irq_timer), .irq_msw(irq_msw),
  .core_rst_req(core_rst_req), .cnt_q(cnt_q), .cmp_q(cmp_q), .ctl_q(ctl_q),
  .sacc_q(sacc_q), .tick(tick), .cnt_wr(cnt_wr)
);

// File: tb/mtimer_unit_tb.sv
`timescale 1ns/1ps
module mtimer_unit_tb;
  logic clk = 0, rst_n = 0;
  logic aux_tick = 0, debug_halt = 0;
  logic req_valid = 0, req_write = 0, req_priv_s = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rsp_rdata;
  logic irq_timer, irq_msw, irq_ssw, core_rst_req;

  always #2.5 clk = ~clk;

  mtimer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .debug_halt(debug_halt),
    .req_valid(req_valid), .req_write(req_write), .req_priv_s(req_priv_s),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_timer(irq_timer), .irq_msw(irq_msw), .irq_ssw(irq_ssw),
    .core_rst_req(core_rst_req)
  );

  int total = 0, bad = 0;
  string cur_req = "R10";
  bit done = 0;

  // behavioural reference
  logic [63:0] m_cnt, m_cmp;
  logic [4:0]  m_ctl;
  bit m_msw, m_ssw, m_sacc, m_pend, m_rst;
  bit ok, cw, tk, hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = '1; m_ctl = 0; m_msw = 0; m_ssw = 0;
      m_sacc = 0; m_pend = 0; m_rst = 0;
    end else begin
      ok  = req_valid && req_write && (!req_priv_s || m_sacc);
      cw  = ok && (req_addr == 16'h0000 || req_addr == 16'h0004 ||
                   req_addr == 16'hCFF8 || req_addr == 16'hCFFC);
      tk  = !m_ctl[0] && !(m_ctl[3] && debug_halt) && (!m_ctl[2] || aux_tick);
      hit = m_cnt >= m_cmp;
      m_rst = ok && req_addr == 16'h0FF0 && req_wdata == 32'h8000_0A5F;
      if (tk && !cw) begin
        if (m_ctl[1] && hit) begin m_cnt = 0; m_pend = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (ok) begin
        case (req_addr)
          16'h0000, 16'hCFF8: m_cnt[31:0]  = req_wdata;
          16'h0004, 16'hCFFC: m_cnt[63:32] = req_wdata;
          16'h0008, 16'h5000: begin m_cmp[31:0]  = req_wdata; m_pend = 0; end
          16'h000C, 16'h5004: begin m_cmp[63:32] = req_wdata; m_pend = 0; end
          16'h0FEC: if (!req_priv_s) m_sacc = req_wdata[0];
          16'h0FF4, 16'hD000: m_ssw = req_wdata[0];
          16'h0FF8: m_ctl = req_wdata[4:0];
          16'h0FFC, 16'h1000: m_msw = req_wdata[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [15:0] a, input bit s);
    if (s && !m_sacc) return 0;
    case (a)
      16'h0000, 16'hCFF8: return m_cnt[31:0];
      16'h0004, 16'hCFFC: return m_cnt[63:32];
      16'h0008, 16'h5000: return m_cmp[31:0];
      16'h000C, 16'h5004: return m_cmp[63:32];
      16'h0FEC: return {31'd0, m_sacc};
      16'h0FF4, 16'hD000: return {31'd0, m_ssw};
      16'h0FF8: return {27'd0, m_ctl};
      16'h0FFC, 16'h1000: return {31'd0, m_msw};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R10 reset outputs", {irq_timer, irq_msw, irq_ssw, core_rst_req}, 4'b0);
      end else begin
        chk({cur_req, " irq_timer"}, irq_timer, (m_cnt >= m_cmp) || m_pend);
        chk({cur_req, " irq_msw"}, irq_msw, m_msw);
        chk({cur_req, " irq_ssw"}, irq_ssw, m_ssw);
        chk({cur_req, " core_rst_req"}, core_rst_req, m_rst);
        if (req_valid && !req_write)
          chk({cur_req, " rdata"}, rsp_rdata, m_read(req_addr, req_priv_s));
      end
    end
  end

  task automatic op(input bit w, input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask
  task automatic wr(input logic [15:0] a, input logic [31:0] d); op(1, a, d); endtask
  task automatic rd(input logic [15:0] a); op(0, a, 0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    @(posedge clk); #1; rst_n = 1;
    cur_req = "R10";
    rd(16'h0008); rd(16'h000C); rd(16'h0FF8);
    wr(16'h0100, 32'hDEAD_BEEF); rd(16'h0100); rd(16'h2000);

    cur_req = "R1";
    idle(5); rd(16'h0004); rd(16'h0000); rd(16'h0004);

    cur_req = "R5";
    wr(16'h0004, 32'h1); wr(16'h0000, 32'hFFFF_FFF0);
    rd(16'h0004); idle(20); rd(16'h0004); rd(16'h0000);

    cur_req = "R2";
    wr(16'h000C, 32'h1); wr(16'h0008, 32'h0000_0030);
    idle(50); rd(16'h0008);
    wr(16'h000C, 32'h2); idle(2);

    cur_req = "R3";
    wr(16'h0FF8, 32'h1); idle(5); rd(16'h0000);
    wr(16'h0FF8, 32'h8); debug_halt = 1; idle(4); rd(16'h0000);
    debug_halt = 0; idle(3); rd(16'h0000);
    wr(16'h0FF8, 32'h4);
    for (int i = 0; i < 12; i++) begin @(posedge clk); #1; aux_tick = i[0]; end
    aux_tick = 0; rd(16'h0000);
    wr(16'h0FF8, 32'h10); idle(3); rd(16'h0000);
    wr(16'h0FF8, 32'hFFFF_FFFF); rd(16'h0FF8); idle(3);
    wr(16'h0FF8, 32'h0);

    cur_req = "R4";
    wr(16'h000C, 32'h0); wr(16'h0004, 32'h0); wr(16'h0000, 32'h0);
    wr(16'h0008, 32'h20); wr(16'h0FF8, 32'h2);
    idle(60); rd(16'h0000);
    wr(16'h0008, 32'h20); idle(3); rd(16'h0000);
    wr(16'h0FF8, 32'h0); wr(16'h000C, 32'hFFFF_FFFF); idle(2);

    cur_req = "R6";
    wr(16'h0FFC, 32'h1); wr(16'h0FF4, 32'h3); rd(16'h0FFC); rd(16'h0FF4);
    wr(16'h0FF4, 32'h0);

    cur_req = "R7";
    req_priv_s = 1;
    rd(16'h0000); wr(16'h0FFC, 32'h0); wr(16'h0FF8, 32'h1); idle(2);
    req_priv_s = 0; rd(16'h0FFC); wr(16'h0FEC, 32'h1);
    req_priv_s = 1;
    wr(16'h0FFC, 32'h0); rd(16'h0000); wr(16'h0FEC, 32'h0); rd(16'h0FEC);
    req_priv_s = 0; wr(16'h0FEC, 32'h0); idle(2);

    cur_req = "R8";
    wr(16'h0FF0, 32'h8000_0A5E); idle(2);
    wr(16'h0FF0, 32'h8000_0A5F); idle(2); rd(16'h0FF0);
    req_priv_s = 1; wr(16'h0FF0, 32'h8000_0A5F); idle(2); req_priv_s = 0;

    cur_req = "R9";
    wr(16'h1000, 32'h1); rd(16'h0FFC); rd(16'h1000);
    wr(16'hD000, 32'h1); rd(16'h0FF4);
    wr(16'h5004, 32'h0); wr(16'h5000, 32'h4000); rd(16'h0008); rd(16'h5004);
    wr(16'hCFFC, 32'h0); wr(16'hCFF8, 32'h100); rd(16'h0000); rd(16'hCFF8);
    idle(40);

    finish_run();
  end
endmodule